// File: doc/BRIEF.md
# Matrix Traversal Address Generator

This block produces the sequence of word addresses needed to visit every element of a square N-by-N matrix whose elements sit in memory row after row, so element (r, c) lives at word r*N + c. A consumer pulls addresses through a valid/ready handshake, one address per accepted transfer. A walk either runs along each row, which gives consecutive addresses, or down each column, which gives a stride of N words between accesses. After the bottom of a column it moves to the top of the next column.

A walk begins when `start_i` is sampled high. At that edge the block captures the order selected by `col_mode_i` and the dimension on `dim_i`. The dimension is forced into the range 2 to 16, so the largest walk covers 256 words and every address fits in 8 bits. After the last address is taken, the block raises a one-cycle completion pulse and then waits for the next start. Sampling `start_i` while a walk is still running abandons that walk and begins again at row 0, column 0.

Top module: `mtx_walk_gen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `vld_o` and `done_o` are both 0.
- R2: In the cycle after `start_i` is sampled high, `vld_o` is 1 and `addr_o` is 0. The order and the dimension are captured only at that start; later changes to `col_mode_i` or `dim_i` have no effect on the running walk.
- R3: With `col_mode_i` = 0 at start, the walk emits the addresses 0, 1, 2, … up to N*N-1 in that order.
- R4: With `col_mode_i` = 1 at start, the k-th address (counting from 0) is (k mod N)*N + (k div N). Consecutive addresses therefore differ by N inside a column, and the address after the bottom of column c is c+1.
- R5: While `vld_o` is 1 and `rdy_i` is 0, `vld_o` stays 1 and `addr_o` keeps its value in the next cycle.
- R6: The walk moves on only in a cycle where `vld_o` and `rdy_i` are both 1. With `rdy_i` held at 1, a walk delivers exactly N*N addresses on N*N consecutive cycles.
- R7: In the cycle after the final address is accepted, `done_o` is 1 for exactly one cycle and `vld_o` is 0. Both then stay at 0 until the next start.
- R8: Sampling `start_i` high during a walk restarts the walk at address 0 in the next cycle. This holds even in the cycle where the final address is accepted. No `done_o` pulse is produced for the abandoned walk.
- R9: A `dim_i` value below 2 is treated as 2, and a value above 16 is treated as 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begins a new walk (also restarts a running one) |
| col_mode_i | input | 1 | Walk order captured at start: 0 along rows, 1 down columns |
| dim_i | input | 5 | Matrix dimension N captured at start, clamped to 2..16 |
| rdy_i | input | 1 | Consumer accepts the current address when high with `vld_o` |
| addr_o | output | 8 | Current word address |
| vld_o | output | 1 | `addr_o` holds a live address |
| done_o | output | 1 | One-cycle pulse after the last address is accepted |

## Verification
The hardest situation to reach is a start that arrives in the same cycle as the acceptance of the final address. In that cycle the block must choose between raising the completion pulse and beginning a new walk. To get there, the bench runs a small walk to its last element, then holds `rdy_i` high and raises `start_i` together. It checks that the next cycle shows address 0 and no pulse. Random walks use random dimensions, some of them outside the legal range. They also change the order and dimension inputs in the middle of a walk and apply random ready patterns. Together these cover holding, clamping and the rule that the inputs are captured only at start.

// File: rtl/mtx_walk_pkg.sv
// Shared types for the matrix traversal address generator.
// Assumes nothing beyond a 1-bit order selector.
package mtx_walk_pkg;

    // Walk order: along rows (unit stride) or down columns (stride of N).
    typedef enum logic {
        WALK_ROWS = 1'b0,
        WALK_COLS = 1'b1
    } walk_order_e;

endpackage

// File: rtl/mtx_walk_ctrl.sv
// Walk controller: captures order and clamped dimension at start, owns the
// valid flag and the completion pulse, and issues load/step strobes to the
// index and address datapaths.
// Assumes last_i is valid whenever vld_o is high; start has priority over
// any handshake in the same cycle.
module mtx_walk_ctrl
    import mtx_walk_pkg::*;
#(
    parameter int DIM_W   = 5,
    parameter int MIN_DIM = 2,
    parameter int MAX_DIM = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             col_mode_i,
    input  logic [DIM_W-1:0] dim_i,
    input  logic             rdy_i,
    input  logic             last_i,
    output logic             vld_o,
    output logic             done_o,
    output logic             load_o,
    output logic             step_o,
    output walk_order_e      order_q,
    output logic [DIM_W-1:0] dim_q
);

    localparam logic [DIM_W-1:0] DIM_LO = DIM_W'(MIN_DIM);
    localparam logic [DIM_W-1:0] DIM_HI = DIM_W'(MAX_DIM);

    logic             vld_q;
    logic             done_q;
    logic [DIM_W-1:0] dim_clamped;

    // Force the requested dimension into the supported range.
    always_comb begin
        if (dim_i < DIM_LO)
            dim_clamped = DIM_LO;
        else if (dim_i > DIM_HI)
            dim_clamped = DIM_HI;
        else
            dim_clamped = dim_i;
    end

    // A start always loads; a step needs a live handshake and no start.
    always_comb begin
        load_o = start_i;
        step_o = vld_q && rdy_i && !start_i;
    end

    // Valid flag, completion pulse and captured walk configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            done_q  <= 1'b0;
            order_q <= WALK_ROWS;
            dim_q   <= DIM_LO;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                vld_q   <= 1'b1;
                order_q <= walk_order_e'(col_mode_i);
                dim_q   <= dim_clamped;
            end else if (step_o && last_i) begin
                vld_q  <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    assign vld_o  = vld_q;
    assign done_o = done_q;

endmodule

// File: rtl/mtx_walk_idx.sv
// Index counters: an inner counter that runs along the current line and an
// outer counter that selects the line. The inner index is the column in row
// order and the row in column order; the mapping is irrelevant here.
// Assumes dim_q is at least 1 and at most 2**CNT_W.
module mtx_walk_idx #(
    parameter int CNT_W = 4,
    parameter int DIM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [DIM_W-1:0] dim_q,
    output logic [CNT_W-1:0] outer_o,
    output logic             wrap_o,
    output logic             last_o
);

    logic [CNT_W-1:0] inner_q;
    logic [CNT_W-1:0] outer_q;
    logic [CNT_W-1:0] dim_m1;

    // Largest index value for the captured dimension.
    always_comb begin
        dim_m1 = CNT_W'(dim_q - DIM_W'(1));
        wrap_o = (inner_q == dim_m1);
        last_o = wrap_o && (outer_q == dim_m1);
    end

    // Advance inner index, carrying into the outer index at line end.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            inner_q <= '0;
            outer_q <= '0;
        end else if (step_i) begin
            if (last_o) begin
                inner_q <= '0;
                outer_q <= '0;
            end else if (wrap_o) begin
                inner_q <= '0;
                outer_q <= outer_q + CNT_W'(1);
            end else begin
                inner_q <= inner_q + CNT_W'(1);
            end
        end
    end

    assign outer_o = outer_q;

endmodule

// File: rtl/mtx_walk_addr.sv
// Address accumulator: keeps the current word address and updates it by
// addition only. Row order adds one (a row end flows into the next row).
// Column order adds N, and at a column end jumps to the top of the next column.
// Assumes ADDR_W > DIM_W and that N*N fits in ADDR_W bits.
module mtx_walk_addr
    import mtx_walk_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 4,
    parameter int DIM_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              last_i,
    input  logic              wrap_i,
    input  walk_order_e       order_q,
    input  logic [DIM_W-1:0]  dim_q,
    input  logic [CNT_W-1:0]  outer_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_nxt;

    // Next address for a step that is not the final one.
    always_comb begin
        if (order_q == WALK_ROWS)
            addr_nxt = addr_q + ADDR_W'(1);
        else if (wrap_i)
            addr_nxt = ADDR_W'(outer_i) + ADDR_W'(1);
        else
            addr_nxt = addr_q + ADDR_W'(dim_q);
    end

    // Register the address; a start returns it to the matrix origin.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i)
            addr_q <= '0;
        else if (step_i && !last_i)
            addr_q <= addr_nxt;
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/mtx_walk_gen.sv
// Matrix traversal address generator: hands out the word addresses of an
// N-by-N row-major matrix over a valid/ready handshake, walking either along
// rows or down columns, with a one-cycle completion pulse.
// Assumes MAX_DIM*MAX_DIM fits in ADDR_W bits.
module mtx_walk_gen
    import mtx_walk_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DIM_W   = 5,
    parameter int MIN_DIM = 2,
    parameter int MAX_DIM = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              col_mode_i,
    input  logic [DIM_W-1:0]  dim_i,
    input  logic              rdy_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              vld_o,
    output logic              done_o
);

    localparam int CNT_W = $clog2(MAX_DIM);

    logic             load_w;
    logic             step_w;
    logic             last_w;
    logic             wrap_w;
    walk_order_e      order_q;
    logic [DIM_W-1:0] dim_q;
    logic [CNT_W-1:0] outer_w;

    mtx_walk_ctrl #(
        .DIM_W   (DIM_W),
        .MIN_DIM (MIN_DIM),
        .MAX_DIM (MAX_DIM)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .col_mode_i (col_mode_i),
        .dim_i      (dim_i),
        .rdy_i      (rdy_i),
        .last_i     (last_w),
        .vld_o      (vld_o),
        .done_o     (done_o),
        .load_o     (load_w),
        .step_o     (step_w),
        .order_q    (order_q),
        .dim_q      (dim_q)
    );

    mtx_walk_idx #(
        .CNT_W (CNT_W),
        .DIM_W (DIM_W)
    ) u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_w),
        .step_i  (step_w),
        .dim_q   (dim_q),
        .outer_o (outer_w),
        .wrap_o  (wrap_w),
        .last_o  (last_w)
    );

    mtx_walk_addr #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .DIM_W  (DIM_W)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_w),
        .step_i  (step_w),
        .last_i  (last_w),
        .wrap_i  (wrap_w),
        .order_q (order_q),
        .dim_q   (dim_q),
        .outer_i (outer_w),
        .addr_o  (addr_o)
    );

endmodule

// File: rtl/mtx_walk_chk.sv
// Property checker for the matrix traversal address generator, bound to the
// top module. Observes ports plus the captured configuration and the
// end-of-line / end-of-walk flags that the index counters drive.
module mtx_walk_chk
    import mtx_walk_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DIM_W   = 5,
    parameter int MIN_DIM = 2,
    parameter int MAX_DIM = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              rdy_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              vld_o,
    input logic              done_o,
    input walk_order_e       order_q,
    input logic [DIM_W-1:0]  dim_q,
    input logic              wrap_w,
    input logic              last_w
);

    // R2
    start_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (vld_o && addr_o == '0 && !done_o));

    // R3
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && rdy_i && !start_i && !last_w && order_q == WALK_ROWS)
        |=> (vld_o && addr_o == $past(addr_o) + ADDR_W'(1)));

    // R4
    col_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && rdy_i && !start_i && !wrap_w && order_q == WALK_COLS)
        |=> (vld_o && addr_o == $past(addr_o) + ADDR_W'($past(dim_q))));

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && !rdy_i && !start_i) |=> (vld_o && $stable(addr_o)));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!vld_o && $past(vld_o && rdy_i && !start_i)));

    // R6
    addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (16'(addr_o) < 16'(dim_q) * 16'(dim_q)));

    // R9
    dim_clamped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dim_q >= DIM_W'(MIN_DIM) && dim_q <= DIM_W'(MAX_DIM)));

endmodule

bind mtx_walk_gen mtx_walk_chk #(
    .ADDR_W  (ADDR_W),
    .DIM_W   (DIM_W),
    .MIN_DIM (MIN_DIM),
    .MAX_DIM (MAX_DIM)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .rdy_i   (rdy_i),
    .addr_o  (addr_o),
    .vld_o   (vld_o),
    .done_o  (done_o),
    .order_q (order_q),
    .dim_q   (dim_q),
    .wrap_w  (wrap_w),
    .last_w  (last_w)
);

// File: tb/mtx_walk_gen_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random walks.
module mtx_walk_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       col_mode_i = 1'b0;
    logic [4:0] dim_i = 5'd8;
    logic       rdy_i = 1'b0;
    logic [7:0] addr_o;
    logic       vld_o;
    logic       done_o;

    int vectors = 0;
    int errors  = 0;

    always #10 clk = ~clk;

    mtx_walk_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .col_mode_i (col_mode_i),
        .dim_i      (dim_i),
        .rdy_i      (rdy_i),
        .addr_o     (addr_o),
        .vld_o      (vld_o),
        .done_o     (done_o)
    );

    function automatic int eff_dim(input int d);
        if (d < 2) return 2;
        if (d > 16) return 16;
        return d;
    endfunction

    function automatic int exp_addr(input logic cols, input int n, input int k);
        if (cols) return (k % n) * n + (k / n);
        return k;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Starts a walk at the current negedge; returns at a negedge either after
    // completion or once abort_after addresses have been accepted.
    task automatic run_walk(input logic cols, input int dim_in, input int pct,
                            input int abort_after, input logic rdy_at_start,
                            input logic restarted);
        int n = eff_dim(dim_in);
        int total = n * n;
        int k = 0;
        int cycles = 0;
        logic held = 1'b0;
        logic acc;
        start_i    = 1'b1;
        col_mode_i = cols;
        dim_i      = 5'(dim_in);
        rdy_i      = rdy_at_start;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 valid after start", int'(vld_o), 1);
        chk("R2 origin address", int'(addr_o), 0);
        if (restarted) chk("R8 no done on restart", int'(done_o), 0);
        forever begin
            if (abort_after >= 0 && k == abort_after) return;
            chk("R6 valid during walk", int'(vld_o), 1);
            chk("R1 done low during walk", int'(done_o), 0);
            if (held)
                chk("R5 held address", int'(addr_o), exp_addr(cols, n, k));
            else if (cols)
                chk("R4 column address", int'(addr_o), exp_addr(cols, n, k));
            else
                chk("R3 row address", int'(addr_o), exp_addr(cols, n, k));
            // R2: scramble the live config inputs; they must be ignored.
            col_mode_i = 1'($urandom);
            dim_i      = 5'($urandom);
            acc = (($urandom % 100) < pct);
            rdy_i = acc;
            held = !acc;
            cycles++;
            @(negedge clk);
            if (acc) begin
                k++;
                if (k == total) begin
                    chk("R7 done pulse", int'(done_o), 1);
                    chk("R7 valid low at done", int'(vld_o), 0);
                    if (pct >= 100) chk("R6 cycles per walk", cycles, total);
                    rdy_i = 1'b1;
                    @(negedge clk);
                    chk("R7 done single cycle", int'(done_o), 0);
                    chk("R7 idle after walk", int'(vld_o), 0);
                    return;
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E_3D4C));
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(vld_o), 0);
        chk("R1 done in reset", int'(done_o), 0);
        rst_n = 1'b1;
        rdy_i = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", int'(vld_o), 0);
        chk("R1 done after reset", int'(done_o), 0);

        // Directed: full 8x8 both orders with ready always high (R3, R4, R6).
        run_walk(1'b0, 8, 100, -1, 1'b0, 1'b0);
        run_walk(1'b1, 8, 100, -1, 1'b0, 1'b0);
        // Clamp both ends (R9), with stalls.
        run_walk(1'b1, 0, 60, -1, 1'b0, 1'b0);
        run_walk(1'b0, 31, 100, -1, 1'b0, 1'b0);
        run_walk(1'b1, 20, 70, -1, 1'b0, 1'b0);
        // Restart mid-walk (R8).
        run_walk(1'b1, 5, 50, 7, 1'b0, 1'b0);
        run_walk(1'b0, 3, 80, 8, 1'b0, 1'b1);
        // Start coincident with acceptance of the last address (R8).
        run_walk(1'b1, 6, 100, -1, 1'b1, 1'b1);

        // Constrained random walks.
        for (int i = 0; i < 14; i++) begin
            run_walk(1'($urandom), int'($urandom % 32), 20 + int'($urandom % 81),
                     -1, 1'b0, 1'b0);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule